// File: doc/BRIEF.md
# ADC Parallel Result Output Formatter

This block places a converter result on a parallel output bus for a host to read. A held copy of the result is taken whenever the load strobe is high. The formatter then applies two run-time options to that held copy. The first option chooses the number coding: plain unsigned binary, or two's complement made by flipping only the top bit. The second option exchanges the upper and lower halves of the word. A host with an 8-bit bus can therefore fetch the whole result from one lane by changing the swap input between its two reads.

The bus is driven only while a read access is in progress, which means chip-select and read-enable are both low. When the block is strapped for serial operation, the bus is released. The output enable is a registered signal and is separate from the data; it stands in for a three-state pin driver. Whenever the enable is low, the data lanes read as zero. Coding and swap act on the held copy through combinational logic. The registered bus therefore follows any change to either input in the cycle after it.

Top module: `adc_par_formatter`

## Requirements
- R1: During synchronous reset and in the first cycle after it, bus_oe is 0, bus_data is all zeros and the held result is zero.
- R2: If cs_n = 0, rd_n = 0 and ser_sel = 0 at a clock edge, bus_oe is 1 after that edge.
- R3: If cs_n or rd_n is 1 at a clock edge, bus_oe is 0 after that edge.
- R4: If ser_sel is 1 at a clock edge, bus_oe is 0 and bus_data is zero after that edge, whatever cs_n and rd_n are.
- R5: With straight_bin = 1 and lane_swap = 0, an enabled bus carries the held result unchanged.
- R6: With straight_bin = 0, only bit DATA_W-1 of the held result is inverted before swapping.
- R7: With lane_swap = 0, bits DATA_W/2-1:0 of the coded result drive bus bits DATA_W/2-1:0. With lane_swap = 1, the two halves exchange lanes.
- R8: The held result takes res_in at a clock edge where res_load = 1. It keeps its value at any edge where res_load = 0.
- R9: A change of straight_bin or lane_swap during an access appears on bus_data after the next clock edge.
- R10: bus_data is all zeros whenever bus_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_in | input | DATA_W | Conversion result |
| res_load | input | 1 | Capture res_in into the held copy |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| ser_sel | input | 1 | 1 = serial strap, parallel bus released |
| straight_bin | input | 1 | 1 = straight binary, 0 = two's complement |
| lane_swap | input | 1 | 1 = exchange upper and lower halves |
| bus_data | output | DATA_W | Registered formatted data, zero when not enabled |
| bus_oe | output | 1 | Registered bus drive enable |

## Verification
The bench builds the block with DATA_W = 8, so each lane is 4 bits wide. This makes it practical to sweep all 256 result values under all four combinations of coding and swap, so every bit is checked for both the top-bit inversion and the lane exchange. At this width the bench can also cover, without sampling, the edge values where the top bit sits next to a lane boundary, the mid-access toggling, and the two-read sequence an 8-bit host would use.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_READ   = 2'd1,
        BUS_SERIAL = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic straight;
        logic swap;
    } fmt_ctrl_t;

    function automatic bus_mode_e decode_mode(input logic ser, input logic cs_n, input logic rd_n);
        if (ser)
            return BUS_SERIAL;
        else if (!cs_n && !rd_n)
            return BUS_READ;
        else
            return BUS_IDLE;
    endfunction

endpackage

// File: rtl/pfmt_hold.sv
module pfmt_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (load)
            held <= din;
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held));

    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> held == $past(din));

endmodule

// File: rtl/pfmt_code.sv
module pfmt_code #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]  held,
    input  pfmt_pkg::fmt_ctrl_t ctrl,
    output logic [DATA_W-1:0]  fmt
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] coded;

    always_comb begin
        coded = held;
        coded[DATA_W-1] = held[DATA_W-1] ^ ~ctrl.straight;
    end

    for (genvar g = 0; g < HALF; g++) begin : g_lane
        assign fmt[g]        = ctrl.swap ? coded[g + HALF] : coded[g];
        assign fmt[g + HALF] = ctrl.swap ? coded[g]        : coded[g + HALF];
    end

endmodule

// File: rtl/pfmt_drive.sv
module pfmt_drive #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              ser_sel,
    input  logic [DATA_W-1:0] fmt,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    import pfmt_pkg::*;

    bus_mode_e mode;

    always_comb mode = decode_mode(ser_sel, cs_n, rd_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_oe   <= 1'b0;
            bus_data <= '0;
        end else begin
            bus_oe   <= (mode == BUS_READ);
            bus_data <= (mode == BUS_READ) ? fmt : '0;
        end
    end

    a_r2_enable: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && !ser_sel) |=> bus_oe);

    a_r3_release: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |=> !bus_oe);

    a_r4_serial: assert property (@(posedge clk) disable iff (rst)
        ser_sel |=> (!bus_oe && bus_data == '0));

    a_r10_zero_lanes: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> bus_data == '0);

endmodule

// File: rtl/adc_par_formatter.sv
module adc_par_formatter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] res_in,
    input  logic              res_load,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              ser_sel,
    input  logic              straight_bin,
    input  logic              lane_swap,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    import pfmt_pkg::*;

    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] fmt;
    fmt_ctrl_t         ctrl;

    assign ctrl.straight = straight_bin;
    assign ctrl.swap     = lane_swap;

    pfmt_hold #(.DATA_W(DATA_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (res_load),
        .din  (res_in),
        .held (held)
    );

    pfmt_code #(.DATA_W(DATA_W)) u_code (
        .held (held),
        .ctrl (ctrl),
        .fmt  (fmt)
    );

    pfmt_drive #(.DATA_W(DATA_W)) u_drive (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .ser_sel  (ser_sel),
        .fmt      (fmt),
        .bus_data (bus_data),
        .bus_oe   (bus_oe)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (!bus_oe && bus_data == '0 && held == '0));

endmodule

// File: tb/adc_par_formatter_test.sv
module adc_par_formatter_test;

    localparam int W = 8;
    localparam int H = W / 2;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] res_in;
    logic         res_load;
    logic         cs_n, rd_n, ser_sel, straight_bin, lane_swap;
    logic [W-1:0] bus_data;
    logic         bus_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adc_par_formatter #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .res_in(res_in), .res_load(res_load),
        .cs_n(cs_n), .rd_n(rd_n), .ser_sel(ser_sel),
        .straight_bin(straight_bin), .lane_swap(lane_swap),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    function automatic logic [W-1:0] expect_fmt(input logic [W-1:0] v, input logic st, input logic sw);
        logic [W-1:0] c;
        c = st ? v : (v ^ (1 << (W - 1)));
        return sw ? {c[H-1:0], c[W-1:H]} : c;
    endfunction

    task automatic check(input string req, input logic oe_exp, input logic [W-1:0] d_exp);
        checks++;
        if (bus_oe !== oe_exp || bus_data !== d_exp) begin
            errors++;
            $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                     req, bus_oe, bus_data, oe_exp, d_exp);
        end
    endtask

    task automatic load_and_read(input logic [W-1:0] v, input logic st, input logic sw);
        @(negedge clk);
        res_in = v; res_load = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
        straight_bin = st; lane_swap = sw;
        @(negedge clk);
        res_load = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: oe=%0b data=%02h expected run to finish", bus_oe, bus_data);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; res_in = '0; res_load = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
        ser_sel = 1'b0; straight_bin = 1'b1; lane_swap = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b0, '0);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        check("R1 held zero", 1'b1, '0);

        // R5 R6 R7: full sweep of value, coding and swap
        for (int v = 0; v < (1 << W); v++) begin
            for (int m = 0; m < 4; m++) begin
                load_and_read(W'(v), m[0], m[1]);
                check(m[1] ? "R7 swapped" : (m[0] ? "R5 straight" : "R6 twos"),
                      1'b1, expect_fmt(W'(v), m[0], m[1]));
            end
        end

        // R9: toggle swap and coding mid-access
        load_and_read(8'hA5, 1'b1, 1'b0);
        check("R9 base", 1'b1, 8'hA5);
        lane_swap = 1'b1;
        @(negedge clk);
        check("R9 swap toggle", 1'b1, 8'h5A);
        straight_bin = 1'b0;
        @(negedge clk);
        check("R9 coding toggle", 1'b1, 8'h52);

        // R7: 8-bit host reads both halves on the low lane
        load_and_read(8'h3C, 1'b1, 1'b0);
        check("R7 low lane first", 1'b1, 8'h3C);
        lane_swap = 1'b1;
        @(negedge clk);
        checks++;
        if (bus_data[H-1:0] !== 4'h3) begin
            errors++;
            $display("FAIL R7 low lane second: %0h expected 3", bus_data[H-1:0]);
        end

        // R8: res_in changes without load leave output unchanged
        lane_swap = 1'b0;
        res_in = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        check("R8 no load", 1'b1, 8'h3C);

        // R3: cs_n high, then rd_n high
        cs_n = 1'b1;
        @(negedge clk);
        check("R3 cs high", 1'b0, '0);
        check("R10 lanes zero", 1'b0, '0);
        cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        check("R3 rd high", 1'b0, '0);
        rd_n = 1'b0;
        @(negedge clk);
        check("R2 re-enable", 1'b1, 8'h3C);

        // R4: serial strap releases bus despite active access
        ser_sel = 1'b1;
        @(negedge clk);
        check("R4 serial", 1'b0, '0);
        ser_sel = 1'b0;
        @(negedge clk);
        check("R2 after serial", 1'b1, 8'h3C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule